// File: doc/BRIEF.md
# Privilege Trap and Vector Base Unit

This unit sits next to a simple instruction decoder. Each cycle it looks at the class of the decoded instruction and at the supervisor bit. It raises a privilege-violation trap when user-mode code tries a supervisor-only operation. Reading the complete status word is one such operation. The other is writing the vector base register. Reading just the condition-code byte is allowed in user mode.

Exception requests from the core go through the same trap path. For every trap the unit gives three things: the vector number, the fetch address of that vector, and the address of the instruction that caused it. A handler can use the instruction address to emulate the instruction and then resume at the next one.

The vector fetch address is the value of a relocatable 32-bit base register plus four times the vector number. After reset the base is zero, so a table at address zero works without any setup. Only supervisor code can change the base. A trap, once raised, stays asserted until the core acknowledges it.

Top module: `priv_vec_unit`

## Requirements
- R1: After reset, trap_o is 0 and the vector base is 0. The first trap with vector n then reports trap_addr_o = 4*n.
- R2: With instr_valid_i=1, instr_class_i=1 (full status read) and super_i=0, trap_o rises on the next clock edge with trap_vec_o=8.
- R3: Some instructions raise no trap when no other request is present. These are class 2 (condition-code read) and class 0 (other) in either mode, and class 1 in supervisor mode.
- R4: vb_wr_i=1 with super_i=1 loads vb_wdata_i into the base at the clock edge. Every later trap uses the new base.
- R5: vb_wr_i=1 with super_i=0 raises a trap with vector 8 and leaves the base unchanged.
- R6: trap_addr_o equals base + trap_vec_o*4, modulo 2^32. The base used is the value the register held in the capture cycle.
- R7: fault_pc_o equals the instr_pc_i that was present in the cycle the trap was captured.
- R8: If a privilege violation and exc_req_i arrive in the same cycle, the violation wins and the vector is 8.
- R9: trap_o, trap_vec_o, trap_addr_o and fault_pc_o stay stable while trap_o=1 and trap_ack_i=0. Requests in that time are dropped. trap_o falls on the edge after trap_ack_i=1.
- R10: exc_req_i=1, with no violation and no pending trap, raises a trap with trap_vec_o=exc_vec_i in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | A decoded instruction is present |
| instr_class_i | input | 2 | 0 other, 1 full status read, 2 condition-code read, 3 other |
| instr_pc_i | input | 32 | Address of the current instruction |
| super_i | input | 1 | Supervisor mode when 1 |
| exc_req_i | input | 1 | Exception request from the core |
| exc_vec_i | input | 8 | Vector number of the exception request |
| vb_wr_i | input | 1 | Write strobe for the vector base |
| vb_wdata_i | input | 32 | New vector base value |
| trap_ack_i | input | 1 | Core accepts the pending trap |
| trap_o | output | 1 | Trap pending |
| trap_vec_o | output | 8 | Vector number of the pending trap |
| trap_addr_o | output | 32 | Fetch address of the vector |
| fault_pc_o | output | 32 | Address of the instruction that trapped |

## Verification
A request is captured at the clock edge that sees it. trap_o and its three fields are valid from that edge on. A base write takes effect at its own edge, so only traps captured later see the new value. The acknowledge clears trap_o at the edge where it is sampled. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares all outputs on the next falling edge against a step model of these rules. That places every check one edge after its stimulus.

// File: rtl/priv_vec_pkg.sv
package priv_vec_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned CLS_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER   = 2'd0,
    CLS_SR_READ = 2'd1,
    CLS_CC_READ = 2'd2,
    CLS_SPARE   = 2'd3
  } instr_cls_e;
endpackage

// File: rtl/priv_check.sv
module priv_check
  import priv_vec_pkg::*;
#(
  parameter int unsigned VW       = VEC_W,
  parameter int unsigned PRIV_VEC = 8
) (
  input  logic          valid_i,
  input  instr_cls_e    cls_i,
  input  logic          super_i,
  input  logic          vb_wr_i,
  input  logic          exc_req_i,
  input  logic [VW-1:0] exc_vec_i,
  output logic          req_o,
  output logic          viol_o,
  output logic [VW-1:0] vec_o
);
  localparam logic [VW-1:0] PV = VW'(PRIV_VEC);

  logic sr_viol, vb_viol;

  always_comb begin
    sr_viol = valid_i && (cls_i == CLS_SR_READ) && !super_i;
    vb_viol = vb_wr_i && !super_i;
    viol_o  = sr_viol || vb_viol;
    req_o   = viol_o || exc_req_i;
    // violation outranks a core exception in the same cycle
    vec_o   = viol_o ? PV : exc_vec_i;
  end

  always_comb begin
    if (valid_i && (cls_i == CLS_CC_READ) && !vb_wr_i) begin
      AST_CC_READ_FREE: assert (!viol_o); // R3
    end
  end
endmodule

// File: rtl/vbase_reg.sv
module vbase_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          super_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               base_q <= '0;
    else if (wr_i && super_i)  base_q <= wdata_i;
  end

  assign base_o = base_q;

  AST_USER_WR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !super_i |=> $stable(base_q)); // R5
  AST_SUP_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && super_i |=> base_q == $past(wdata_i)); // R4
endmodule

// File: rtl/vec_addr.sv
module vec_addr #(
  parameter int unsigned AW    = 32,
  parameter int unsigned VW    = 8,
  parameter int unsigned SHIFT = 2
) (
  input  logic [AW-1:0] base_i,
  input  logic [VW-1:0] vec_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned OFF_W = VW + SHIFT;

  logic [OFF_W-1:0] off;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign off = vec_i;
    end else begin : g_shift
      assign off = {vec_i, {SHIFT{1'b0}}};
    end
  endgenerate

  assign addr_o = base_i + AW'(off);
endmodule

// File: rtl/trap_hold.sv
module trap_hold #(
  parameter int unsigned AW = 32,
  parameter int unsigned VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [VW-1:0] vec_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] pc_i,
  input  logic          ack_i,
  output logic          trap_o,
  output logic [VW-1:0] vec_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] pc_o
);
  logic          pend_q;
  logic [VW-1:0] vec_q;
  logic [AW-1:0] addr_q, pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
      pc_q   <= '0;
    end else if (pend_q) begin
      if (ack_i) pend_q <= 1'b0;
    end else if (req_i) begin
      pend_q <= 1'b1;
      vec_q  <= vec_i;
      addr_q <= addr_i;
      pc_q   <= pc_i;
    end
  end

  assign trap_o = pend_q;
  assign vec_o  = vec_q;
  assign addr_o = addr_q;
  assign pc_o   = pc_q;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i |=> pend_q && $stable(vec_q) && $stable(addr_q) && $stable(pc_q)); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && ack_i |=> !pend_q); // R9
  AST_PC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && req_i |=> pend_q && pc_q == $past(pc_i)); // R7
endmodule

// File: rtl/priv_vec_unit.sv
module priv_vec_unit
  import priv_vec_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned VW       = VEC_W,
  parameter int unsigned PRIV_VEC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [1:0]    instr_class_i,
  input  logic [AW-1:0] instr_pc_i,
  input  logic          super_i,
  input  logic          exc_req_i,
  input  logic [VW-1:0] exc_vec_i,
  input  logic          vb_wr_i,
  input  logic [AW-1:0] vb_wdata_i,
  input  logic          trap_ack_i,
  output logic          trap_o,
  output logic [VW-1:0] trap_vec_o,
  output logic [AW-1:0] trap_addr_o,
  output logic [AW-1:0] fault_pc_o
);
  logic          req, viol;
  logic [VW-1:0] req_vec;
  logic [AW-1:0] base, req_addr;
  instr_cls_e    cls;

  assign cls = instr_cls_e'(instr_class_i);

  priv_check #(.VW(VW), .PRIV_VEC(PRIV_VEC)) u_check (
    .valid_i   (instr_valid_i),
    .cls_i     (cls),
    .super_i   (super_i),
    .vb_wr_i   (vb_wr_i),
    .exc_req_i (exc_req_i),
    .exc_vec_i (exc_vec_i),
    .req_o     (req),
    .viol_o    (viol),
    .vec_o     (req_vec)
  );

  vbase_reg #(.AW(AW)) u_vbase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (vb_wr_i),
    .super_i (super_i),
    .wdata_i (vb_wdata_i),
    .base_o  (base)
  );

  vec_addr #(.AW(AW), .VW(VW), .SHIFT(2)) u_addr (
    .base_i (base),
    .vec_i  (req_vec),
    .addr_o (req_addr)
  );

  trap_hold #(.AW(AW), .VW(VW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .vec_i  (req_vec),
    .addr_i (req_addr),
    .pc_i   (instr_pc_i),
    .ack_i  (trap_ack_i),
    .trap_o (trap_o),
    .vec_o  (trap_vec_o),
    .addr_o (trap_addr_o),
    .pc_o   (fault_pc_o)
  );

  AST_USER_SR_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o && instr_valid_i && instr_class_i == 2'd1 && !super_i
    |=> trap_o && trap_vec_o == VW'(PRIV_VEC)); // R2
  AST_VIOL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o && viol && exc_req_i |=> trap_vec_o == VW'(PRIV_VEC)); // R8
  AST_EXC_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o && exc_req_i && !viol |=> trap_o && trap_vec_o == $past(exc_vec_i)); // R10
  AST_ADDR_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o && req |=> trap_addr_o == $past(base) + (AW'(trap_vec_o) << 2)); // R6
endmodule

// File: tb/test_priv_vec_unit.sv
module test_priv_vec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sup = 1'b0, exc = 1'b0, vbwr = 1'b0, ack = 1'b0;
  logic [1:0]  cls = 2'd0;
  logic [31:0] pc = '0, wd = '0;
  logic [7:0]  ev = '0;
  logic        trap;
  logic [7:0]  tvec;
  logic [31:0] taddr, fpc;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic        m_trap = 0;
  logic [7:0]  m_vec = 0;
  logic [31:0] m_addr = 0, m_pc = 0, m_base = 0;

  always #2 clk = ~clk;

  priv_vec_unit i_priv_vec_unit (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_class_i(cls),
    .instr_pc_i(pc), .super_i(sup), .exc_req_i(exc), .exc_vec_i(ev),
    .vb_wr_i(vbwr), .vb_wdata_i(wd), .trap_ack_i(ack), .trap_o(trap),
    .trap_vec_o(tvec), .trap_addr_o(taddr), .fault_pc_o(fpc)
  );

  function automatic logic [31:0] vaddr(logic [31:0] b, logic [7:0] v);
    return b + {22'd0, v, 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " trap"}, {31'd0, trap}, {31'd0, m_trap});
    if (m_trap) begin
      chk({tag, " vec"}, {24'd0, tvec}, {24'd0, m_vec});
      chk({tag, " addr R6"}, taddr, m_addr);
      chk({tag, " pc R7"}, fpc, m_pc);
    end
  endtask

  // drive at negedge, one posedge, check at next negedge
  task automatic step(string tag, logic v, logic [1:0] c, logic s, logic [31:0] p,
                      logic e, logic [7:0] en, logic w, logic [31:0] d, logic a);
    logic viol;
    valid = v; cls = c; sup = s; pc = p; exc = e; ev = en; vbwr = w; wd = d; ack = a;
    @(posedge clk);
    viol = (v && c == 2'd1 && !s) || (w && !s);
    if (m_trap) begin
      if (a) m_trap = 0;
    end else if (viol || e) begin
      m_trap = 1;
      m_vec  = viol ? 8'd8 : en;
      m_addr = vaddr(m_base, m_vec);
      m_pc   = p;
    end
    if (w && s) m_base = d;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 1, 32'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain(string tag);
    step(tag, 0, 0, 1, 32'h0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    chk("R1 reset trap", {31'd0, trap}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'd0, trap}, 32'd0);

    step("R1 zero base", 1, 0, 1, 32'h100, 1, 8'd5, 0, 0, 0);
    chk("R1 addr", taddr, 32'd20);
    drain("R9 ack");
    chk("R9 cleared", {31'd0, trap}, 32'd0);

    step("R2 user sr read", 1, 1, 0, 32'h2000, 0, 0, 0, 0, 0);
    chk("R2 vec", {24'd0, tvec}, 32'd8);
    chk("R7 pc", fpc, 32'h2000);
    step("R9 held", 1, 0, 1, 32'h2004, 1, 8'd9, 0, 0, 0);
    chk("R9 vec still 8", {24'd0, tvec}, 32'd8);
    drain("R9 ack2");

    step("R3 user cc read", 1, 2, 0, 32'h3000, 0, 0, 0, 0, 0);
    step("R3 sup sr read", 1, 1, 1, 32'h3002, 0, 0, 0, 0, 0);
    step("R3 user other", 1, 0, 0, 32'h3004, 0, 0, 0, 0, 0);
    chk("R3 no trap", {31'd0, trap}, 32'd0);

    step("R4 sup write", 1, 0, 1, 32'h4000, 0, 0, 1, 32'h1000, 0);
    step("R4 exc", 1, 0, 1, 32'h4002, 1, 8'd3, 0, 0, 0);
    chk("R4 addr", taddr, 32'h100C);
    drain("R4 ack");

    step("R5 user write", 1, 0, 0, 32'h5000, 0, 0, 1, 32'hDEAD0000, 0);
    chk("R5 vec", {24'd0, tvec}, 32'd8);
    chk("R5 addr", taddr, 32'h1020);
    drain("R5 ack");
    step("R5 base kept", 1, 0, 0, 32'h5004, 1, 8'd0, 0, 0, 0);
    chk("R5 addr base", taddr, 32'h1000);
    drain("R5 ack2");

    step("R8 both", 1, 1, 0, 32'h6000, 1, 8'd40, 0, 0, 0);
    chk("R8 vec", {24'd0, tvec}, 32'd8);
    drain("R8 ack");

    step("R10 user exc", 1, 2, 0, 32'h7000, 1, 8'd77, 0, 0, 0);
    chk("R10 vec", {24'd0, tvec}, 32'd77);
    drain("R10 ack");

    step("R6 wrap base", 1, 0, 1, 32'h8000, 0, 0, 1, 32'hFFFFFFF0, 0);
    step("R6 wrap", 1, 0, 1, 32'h8002, 1, 8'd255, 0, 0, 0);
    chk("R6 wrap addr", taddr, 32'h000003EC);
    drain("R6 ack");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R9 random", r[0] | r[1], r[3:2], r[4], $urandom, r[7:5] == 3'd0,
           r[15:8], r[19:16] == 4'd0, $urandom, r[20] & r[21]);
    end
    idle("R9 end");
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule